// File: doc/BRIEF.md
# Dual-Channel IDE Bus-Master Register File

This block is the register file of a two-channel IDE bus-master DMA controller. It occupies a 16-byte I/O window that is split into one 8-byte slot per channel. Each slot contains three registers: a command byte, a status byte, and a 32-bit pointer to the channel's descriptor table. The command byte and status byte share the lower four bytes of the slot. The pointer fills the upper four bytes.

Software reaches the block through a single-cycle request port that carries an address, a read/write flag, an access size and write data. Read data appears in the cycle after a read request.

The command byte and status byte accept only byte-wide accesses. A wider read returns all ones, and a wider write is dropped. The status byte mixes bit types:
- two bits are ordinary read/write flags;
- one bit (active) is owned by the DMA engine;
- two bits (error and interrupt) are set by the engine and cleared by software writing a one.

Each command byte write is forwarded to the DMA engine as a one-cycle strobe. The strobe carries the channel number and the data. The engine drives per-channel pulses back into the block to set or clear the status bits it owns.

Top module: `ide_bm_regfile`

## Requirements
- R1: Channel n (n = 0 or 1) is selected by address bit 3. Within a slot, local offset 0 is the command byte, local offset 2 is the status byte, and local offsets 4 to 7 are the descriptor pointer. Accesses to one channel never change the other channel's registers.
- R2: A byte read at local offset 1 or 3 returns 0x000000FF. A byte write at those offsets changes no register and raises no command strobe.
- R3: The size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. At local offsets 0 to 3, a read with a size code other than 0 returns 0x0000FFFF (2 bytes) or 0xFFFFFFFF (4 bytes). A write with a size code other than 0 is dropped and raises no command strobe.
- R4: A byte write to status loads bits 5 and 6 from the write data and leaves bit 0 unchanged. Bits 3, 4 and 7 always read as 0. Bits 31:8 of every status read are 0.
- R5: In a status write, a 1 in bit 1 or bit 2 of the data clears that status bit, and a 0 leaves it unchanged.
- R6: Per-channel set pulses for active (bit 0), error (bit 1) and interrupt (bit 2) win over a clearing write in the same cycle. Bit 0 is cleared only by the engine's clear-active pulse. If set-active and clear-active arrive together, bit 0 ends up 1.
- R7: A byte write to the command byte stores the byte, which reads back at offset 0. In the following cycle only, the command strobe is high and carries the channel number and the written byte.
- R8: The descriptor pointer is written only by a 4-byte write at local offset 4, and it stores data bits 1:0 as zero. A read at offset 4+k (k = 0 to 3) returns the pointer shifted right by 8*k bits, cut to the access width.
- R9: After reset, every command byte, status byte and pointer reads 0, read data is 0 and the strobe is low.
- R10: Read data changes only in the cycle after a read request. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address within the window |
| req_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| req_wdata | input | 32 | Write data, least significant byte at the addressed byte |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read request |
| hw_set_active | input | 2 | Per-channel pulse setting status bit 0 |
| hw_clr_active | input | 2 | Per-channel pulse clearing status bit 0 |
| hw_set_error | input | 2 | Per-channel pulse setting status bit 1 |
| hw_set_irq | input | 2 | Per-channel pulse setting status bit 2 |
| cmd_wr_valid | output | 1 | One-cycle command-write strobe to the DMA engine |
| cmd_wr_chan | output | 1 | Channel of the command write |
| cmd_wr_data | output | 8 | Byte written to the command register |

## Verification
The bench builds the block with its default of two channels. With that default, the window is 4 bits wide and the channel select is a single address bit, so both slots can be addressed. This lets the bench check that each slot is isolated from the other, as well as the offset-1 and offset-3 bytes at the far end of each slot. At this size, every combination of access size and local offset can be reached from one table. This includes shifted narrow reads of the pointer and wide accesses to the byte group. Same-cycle collisions between engine pulses and software writes are then driven on each channel separately.

// File: rtl/ide_bm_regfile.sv
module ide_bm_regfile #(
  parameter int CHANNELS = 2,
  localparam int ADDR_W = $clog2(CHANNELS * 8),
  localparam int CH_W = $clog2(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [31:0]         req_wdata,
  output logic [31:0]         rsp_rdata,
  input  logic [CHANNELS-1:0] hw_set_active,
  input  logic [CHANNELS-1:0] hw_clr_active,
  input  logic [CHANNELS-1:0] hw_set_error,
  input  logic [CHANNELS-1:0] hw_set_irq,
  output logic                cmd_wr_valid,
  output logic [CH_W-1:0]     cmd_wr_chan,
  output logic [7:0]          cmd_wr_data
);

  localparam logic [7:0] STS_RW  = 8'h60;
  localparam logic [7:0] STS_W1C = 8'h06;
  localparam logic [7:0] STS_HW  = 8'h01;

  logic [CH_W-1:0] sel_ch;
  logic [2:0]      loc;
  logic            is_byte, is_word, wr, rd;
  logic            wr_cmd, wr_sts, wr_adr;

  assign sel_ch  = req_addr[ADDR_W-1:3];
  assign loc     = req_addr[2:0];
  assign is_byte = (req_size == 2'd0);
  assign is_word = req_size[1];
  assign wr      = req_valid & req_write;
  assign rd      = req_valid & ~req_write;
  assign wr_cmd  = wr & is_byte & (loc == 3'd0);
  assign wr_sts  = wr & is_byte & (loc == 3'd2);
  assign wr_adr  = wr & is_word & (loc == 3'd4);

  logic [CHANNELS-1:0][7:0]  cmd_v;
  logic [CHANNELS-1:0][7:0]  sts_v;
  logic [CHANNELS-1:0][31:0] adr_v;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic       hit;
    logic [7:0] cmd_q, sts_q, sts_sw, sts_nx;
    logic [31:0] adr_q;

    assign hit = (sel_ch == CH_W'(c));

    always_comb begin
      sts_sw = sts_q;
      if (wr_sts && hit)
        sts_sw = (req_wdata[7:0] & STS_RW) | (sts_q & STS_HW) |
                 (sts_q & ~req_wdata[7:0] & STS_W1C);
      sts_nx = sts_sw;
      if (hw_clr_active[c]) sts_nx[0] = 1'b0;
      if (hw_set_active[c]) sts_nx[0] = 1'b1;
      if (hw_set_error[c])  sts_nx[1] = 1'b1;
      if (hw_set_irq[c])    sts_nx[2] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q <= '0;
        sts_q <= '0;
        adr_q <= '0;
      end else begin
        if (wr_cmd && hit) cmd_q <= req_wdata[7:0];
        sts_q <= sts_nx;
        if (wr_adr && hit) adr_q <= {req_wdata[31:2], 2'b00};
      end
    end

    assign cmd_v[c] = cmd_q;
    assign sts_v[c] = sts_q;
    assign adr_v[c] = adr_q;
  end

  logic [31:0] mask, adr_sh, rd_val;

  assign mask   = is_byte ? 32'h0000_00FF :
                  (req_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign adr_sh = adr_v[sel_ch] >> {loc[1:0], 3'b000};

  always_comb begin
    if (loc[2])
      rd_val = adr_sh & mask;
    else if (!is_byte)
      rd_val = mask;
    else begin
      case (loc[1:0])
        2'd0:    rd_val = {24'd0, cmd_v[sel_ch]};
        2'd2:    rd_val = {24'd0, sts_v[sel_ch]};
        default: rd_val = 32'h0000_00FF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata    <= '0;
      cmd_wr_valid <= 1'b0;
      cmd_wr_chan  <= '0;
      cmd_wr_data  <= '0;
    end else begin
      if (rd) rsp_rdata <= rd_val;
      cmd_wr_valid <= wr_cmd;
      if (wr_cmd) begin
        cmd_wr_chan <= sel_ch;
        cmd_wr_data <= req_wdata[7:0];
      end
    end
  end

endmodule

// File: rtl/ide_bm_regfile_chk.sv
module ide_bm_regfile_chk #(
  parameter int CHANNELS = 2,
  localparam int ADDR_W = $clog2(CHANNELS * 8),
  localparam int CH_W = $clog2(CHANNELS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [7:0]        wdata_lo,
  input logic [31:0]       rsp_rdata,
  input logic              cmd_wr_valid,
  input logic [CH_W-1:0]   cmd_wr_chan,
  input logic [7:0]        cmd_wr_data
);

  logic rd_req, wr_cmd_req;
  assign rd_req     = req_valid && !req_write;
  assign wr_cmd_req = req_valid && req_write && req_size == 2'd0 && req_addr[2:0] == 3'd0;

  AST_CMD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_req |=> cmd_wr_valid && cmd_wr_data == $past(wdata_lo) &&
                   cmd_wr_chan == $past(req_addr[ADDR_W-1:3])); // R7

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_valid |-> $past(wr_cmd_req)); // R3

  AST_WIDE_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !req_addr[2] && req_size != 2'd0) |=>
      rsp_rdata == (($past(req_size) == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF)); // R3

  AST_PAD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_size == 2'd0 && !req_addr[2] && req_addr[0]) |=>
      rsp_rdata == 32'h0000_00FF); // R2

  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_size == 2'd0 && req_addr[2:0] == 3'd2) |=>
      (rsp_rdata & 32'hFFFF_FF98) == 32'd0); // R4

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_size[1] && req_addr[2:0] == 3'd4) |=> rsp_rdata[1:0] == 2'b00); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rsp_rdata)); // R10

endmodule

bind ide_bm_regfile ide_bm_regfile_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .wdata_lo(req_wdata[7:0]),
  .rsp_rdata(rsp_rdata), .cmd_wr_valid(cmd_wr_valid),
  .cmd_wr_chan(cmd_wr_chan), .cmd_wr_data(cmd_wr_data)
);

// File: tb/ide_bm_regfile_test.sv
`timescale 1ns/1ps
module ide_bm_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [1:0]  hw_set_active = '0, hw_clr_active = '0, hw_set_error = '0, hw_set_irq = '0;
  logic        cmd_wr_valid;
  logic [0:0]  cmd_wr_chan;
  logic [7:0]  cmd_wr_data;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ide_bm_regfile uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .hw_set_active(hw_set_active),
    .hw_clr_active(hw_clr_active), .hw_set_error(hw_set_error),
    .hw_set_irq(hw_set_irq), .cmd_wr_valid(cmd_wr_valid),
    .cmd_wr_chan(cmd_wr_chan), .cmd_wr_data(cmd_wr_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, after the result is registered.
  task automatic access(input bit w, input logic [1:0] sz, input logic [3:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] sz, input logic [3:0] a, input logic [31:0] exp);
    access(1'b0, sz, a, 32'd0);
    check(req, rsp_rdata, exp);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // {tag[3:0], write, size[1:0], addr[3:0], wdata[31:0], expected[31:0]}
  localparam int NV = 26;
  localparam logic [74:0] VEC [NV] = '{
    {4'd7, 1'b1, 2'd0, 4'h0, 32'h0000_0009, 32'h0},          // R7 command write ch0
    {4'd7, 1'b0, 2'd0, 4'h0, 32'h0,         32'h0000_0009},  // R7
    {4'd1, 1'b1, 2'd0, 4'h8, 32'h0000_0001, 32'h0},          // R1 command write ch1
    {4'd1, 1'b0, 2'd0, 4'h8, 32'h0,         32'h0000_0001},  // R1
    {4'd2, 1'b0, 2'd0, 4'h1, 32'h0,         32'h0000_00FF},  // R2
    {4'd2, 1'b0, 2'd0, 4'hB, 32'h0,         32'h0000_00FF},  // R2
    {4'd2, 1'b1, 2'd0, 4'h3, 32'h0000_0055, 32'h0},          // R2 ignored write
    {4'd2, 1'b0, 2'd0, 4'h0, 32'h0,         32'h0000_0009},  // R2
    {4'd2, 1'b0, 2'd0, 4'h2, 32'h0,         32'h0000_0000},  // R2
    {4'd3, 1'b0, 2'd1, 4'h0, 32'h0,         32'h0000_FFFF},  // R3
    {4'd3, 1'b0, 2'd2, 4'h8, 32'h0,         32'hFFFF_FFFF},  // R3
    {4'd3, 1'b1, 2'd2, 4'h0, 32'h0000_00AA, 32'h0},          // R3 dropped wide write
    {4'd3, 1'b0, 2'd0, 4'h0, 32'h0,         32'h0000_0009},  // R3
    {4'd3, 1'b1, 2'd1, 4'h2, 32'h0000_0060, 32'h0},          // R3 dropped half write
    {4'd3, 1'b0, 2'd0, 4'h2, 32'h0,         32'h0000_0000},  // R3
    {4'd4, 1'b1, 2'd0, 4'h2, 32'h0000_00FF, 32'h0},          // R4
    {4'd4, 1'b0, 2'd0, 4'h2, 32'h0,         32'h0000_0060},  // R4
    {4'd8, 1'b1, 2'd2, 4'h4, 32'h1234_5677, 32'h0},          // R8
    {4'd8, 1'b0, 2'd2, 4'h4, 32'h0,         32'h1234_5674},  // R8
    {4'd8, 1'b0, 2'd0, 4'h5, 32'h0,         32'h0000_0056},  // R8
    {4'd8, 1'b0, 2'd1, 4'h6, 32'h0,         32'h0000_1234},  // R8
    {4'd8, 1'b1, 2'd0, 4'hC, 32'h0000_00AB, 32'h0},          // R8 byte write dropped
    {4'd8, 1'b0, 2'd2, 4'hC, 32'h0,         32'h0000_0000},  // R8
    {4'd8, 1'b1, 2'd2, 4'hC, 32'hCAFE_F00D, 32'h0},          // R8
    {4'd8, 1'b0, 2'd2, 4'hC, 32'h0,         32'hCAFE_F00C},  // R8
    {4'd1, 1'b0, 2'd2, 4'h4, 32'h0,         32'h1234_5674}   // R1 ch0 pointer intact
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R9 rdata", rsp_rdata, 32'd0);
    check("R9 strobe", {31'd0, cmd_wr_valid}, 32'd0);
    rst_n = 1'b1;
    idle();
    rd("R9 cmd0", 2'd0, 4'h0, 32'd0);
    rd("R9 sts1", 2'd0, 4'hA, 32'd0);
    rd("R9 ptr0", 2'd2, 4'h4, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [74:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d vec%0d", e[74:71], i);
      access(e[70], e[69:68], e[67:64], e[63:32]);
      if (e[70]) begin
        logic exp_stb;
        exp_stb = (e[69:68] == 2'd0) && (e[66:64] == 3'd0);
        check({tag, " strobe"}, {31'd0, cmd_wr_valid}, {31'd0, exp_stb});
        if (exp_stb)
          check({tag, " strobe chan/data"}, {23'd0, cmd_wr_chan, cmd_wr_data},
                {23'd0, e[67], e[39:32]});
      end else
        check(tag, rsp_rdata, e[31:0]);
    end

    // R7 strobe lasts one cycle only
    access(1'b1, 2'd0, 4'h8, 32'h0000_00C3);
    check("R7 strobe high", {23'd0, cmd_wr_valid, cmd_wr_data}, {23'd0, 1'b1, 8'hC3});
    check("R7 strobe chan", {31'd0, cmd_wr_chan}, 32'd1);
    idle();
    check("R7 strobe low", {31'd0, cmd_wr_valid}, 32'd0);

    // R5: set error, set irq, then write-one-to-clear
    hw_set_error = 2'b01; idle(); hw_set_error = '0;
    rd("R5 err set", 2'd0, 4'h2, 32'h62);
    hw_set_irq = 2'b01; idle(); hw_set_irq = '0;
    rd("R5 irq set", 2'd0, 4'h2, 32'h66);
    access(1'b1, 2'd0, 4'h2, 32'h62);
    rd("R5 clear bit1", 2'd0, 4'h2, 32'h64);

    // R6: set pulse wins over clear in the same cycle
    hw_set_irq = 2'b01; access(1'b1, 2'd0, 4'h2, 32'h64); hw_set_irq = '0;
    rd("R6 irq vs w1c", 2'd0, 4'h2, 32'h64);
    hw_set_error = 2'b01; access(1'b1, 2'd0, 4'h2, 32'h04); hw_set_error = '0;
    rd("R6 err during write", 2'd0, 4'h2, 32'h02);

    hw_set_active = 2'b10; idle(); hw_set_active = '0;
    rd("R6 active set ch1", 2'd0, 4'hA, 32'h01);
    rd("R1 ch0 untouched", 2'd0, 4'h2, 32'h02);
    access(1'b1, 2'd0, 4'hA, 32'h00);
    rd("R4 bit0 kept", 2'd0, 4'hA, 32'h01);
    hw_set_active = 2'b10; hw_clr_active = 2'b10; idle();
    hw_set_active = '0; hw_clr_active = '0;
    rd("R6 set beats clr", 2'd0, 4'hA, 32'h01);
    hw_clr_active = 2'b10; idle(); hw_clr_active = '0;
    rd("R6 active clear", 2'd0, 4'hA, 32'h00);

    // R10 read data holds across writes and idle cycles
    rd("R10 setup", 2'd0, 4'h0, 32'h09);
    access(1'b1, 2'd0, 4'hA, 32'h20);
    idle(); idle();
    check("R10 hold", rsp_rdata, 32'h09);

    // R9 reset mid-run
    rst_n = 1'b0; idle(); idle();
    rst_n = 1'b1; idle();
    rd("R9 cmd0 after reset", 2'd0, 4'h0, 32'd0);
    rd("R9 sts1 after reset", 2'd0, 4'hA, 32'd0);
    rd("R9 ptr1 after reset", 2'd2, 4'hC, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule